// File: doc/BRIEF.md
# PRBS Word Generator and Lock Checker

This block pairs a pseudo-random word source with a matching receiver-side checker, for proving out a loopback path such as a wide parallel pin bus or a serial lane. Every word is the full state of a 17-bit shift register built on the polynomial x^17 + x^14 + 1. In the parallel-bus use, each bit of the word maps to one physical pin. The source offers a fresh word on every clock in which its consumer accepts one.

The checker needs no shared seed. It first rebuilds the transmitter's register from the bit-0 column of the words it receives. It then predicts each following word and compares it in full. A lock state machine with hysteresis declares lock after a programmable run of correct words. It drops lock after a programmable run of wrong words. While locked, every wrong word produces a one-cycle error strobe and a mask of the bit positions that differed.

Both data paths are valid/ready streams. The source holds `gen_valid` high from the first clock after reset. It advances only on a cycle where `gen_valid` and `gen_ready` are both high, so a low `gen_ready` freezes `gen_data`. The checker's `rx_ready` follows `link_up`. A word transfers when `rx_valid` and `rx_ready` are both high, and nothing else on `rx_data` has any effect.

Top module: `prbs_lock_pair`

## Requirements
- R1: Reset sets the source word to the seed 17'h00001, `gen_valid` low, `locked` low, `err_pulse` low and `err_mask` zero. Each source step shifts the word left by one. The new bit 0 is the XOR of old bits 16 and 13.
- R2: The source word returns to the seed after exactly 131071 steps, and not earlier.
- R3: `gen_valid` is high from the first clock after reset. `gen_data` steps one cycle after a cycle with `gen_ready` high and stays unchanged while `gen_ready` is low.
- R4: After a reseed, the checker takes only bit 0 of each of the next 17 transferred words, shifting it into bit 0 of its register. The word after those 17 is the first one compared.
- R5: In acquisition, lock is declared in the cycle after the `lock_run`-th consecutive correct word. A `lock_run` of 0 acts as 1.
- R6: A wrong word during acquisition restarts the count of correct words.
- R7: While locked, a wrong word makes `err_pulse` high for the next cycle only. In that cycle `err_mask` equals received XOR predicted. Otherwise `err_mask` is zero.
- R8: A wrong word while not locked leaves `err_pulse` low and `err_mask` zero.
- R9: While locked, lock drops in the cycle after the `unlock_run`-th consecutive wrong word. A correct word restarts that count.
- R10: After lock drops, a new run of `lock_run` correct words relocks without reseeding.
- R11: With `link_up` low, `rx_ready` is low and transferred words are ignored. In the next cycle the checker is unlocked, and it reseeds per R4 once `link_up` returns.
- R12: An all-zero checker register after seeding forces a reseed. A stream of all-zero words therefore never locks.
- R13: Cycles with `rx_valid` low change neither the checker register nor its run counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| gen_valid | output | 1 | Source word available |
| gen_ready | input | 1 | Consumer takes the source word |
| gen_data | output | 17 | Source pseudo-random word |
| rx_valid | input | 1 | Received word present |
| rx_ready | output | 1 | Checker accepts words (equals link_up) |
| rx_data | input | 17 | Received word |
| link_up | input | 1 | Checker enable; low forces a reseed |
| lock_run | input | 8 | Correct words needed to lock |
| unlock_run | input | 8 | Wrong words needed to lose lock |
| locked | output | 1 | Checker is locked |
| err_pulse | output | 1 | One-cycle strobe per wrong word while locked |
| err_mask | output | 17 | Bit positions in error for the strobed word |

## Verification
The source word, `locked`, `err_pulse` and `err_mask` all come from registers. Each of them therefore shows its response in the cycle after the handshake or `link_up` change that causes it. The bench drives inputs on the falling edge and samples one falling edge later, which is the first point where that single-register response is visible. It never samples at the rising edge itself. Runs of correct and wrong words are counted in transferred words rather than cycles. Idle cycles with `rx_valid` low are placed between words, so the checks confirm that gaps do not shift the moment lock is declared.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  typedef enum logic [1:0] {
    ST_SEED = 2'd0,
    ST_HUNT = 2'd1,
    ST_LOCK = 2'd2
  } chk_state_t;
endpackage

// File: rtl/prbs_step.sv
module prbs_step #(
  parameter int LEN    = 17,
  parameter int TAP_HI = 16,
  parameter int TAP_LO = 13
) (
  input  logic [LEN-1:0] cur,
  output logic [LEN-1:0] nxt
);
  assign nxt[0] = cur[TAP_HI] ^ cur[TAP_LO];

  for (genvar i = 1; i < LEN; i++) begin : g_shift
    assign nxt[i] = cur[i-1];
  end
endmodule

// File: rtl/prbs_gen.sv
module prbs_gen #(
  parameter int LEN    = 17,
  parameter int TAP_HI = 16,
  parameter int TAP_LO = 13,
  parameter logic [LEN-1:0] SEED = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ready,
  output logic           valid,
  output logic [LEN-1:0] data
);
  logic [LEN-1:0] state_q;
  logic [LEN-1:0] state_nxt;
  logic           vld_q;

  prbs_step #(.LEN(LEN), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_step (
    .cur (state_q),
    .nxt (state_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= 1'b1;
      if (vld_q && ready) state_q <= state_nxt;
    end
  end

  assign valid = vld_q;
  assign data  = state_q;
endmodule

// File: rtl/prbs_lock_fsm.sv
module prbs_lock_fsm
  import prbs_pkg::*;
#(
  parameter int SEED_LEN = 17,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             link_up,
  input  logic             acc,
  input  logic             match,
  input  logic             lfsr_zero,
  input  logic [CNT_W-1:0] lock_run,
  input  logic [CNT_W-1:0] unlock_run,
  output chk_state_t       st
);
  localparam int SEED_W = $clog2(SEED_LEN);
  localparam logic [SEED_W-1:0] SEED_LAST = SEED_W'(SEED_LEN - 1);
  localparam logic [SEED_W-1:0] SEED_ONE  = SEED_W'(1);
  localparam logic [CNT_W:0]    CNT_ONE   = (CNT_W+1)'(1);

  chk_state_t        st_q;
  logic [SEED_W-1:0] seed_cnt;
  logic [CNT_W-1:0]  good_cnt;
  logic [CNT_W-1:0]  bad_cnt;
  logic [CNT_W:0]    good_inc;
  logic [CNT_W:0]    bad_inc;
  logic              good_done;
  logic              bad_done;

  always_comb begin
    good_inc  = {1'b0, good_cnt} + CNT_ONE;
    bad_inc   = {1'b0, bad_cnt} + CNT_ONE;
    good_done = good_inc >= {1'b0, lock_run};
    bad_done  = bad_inc >= {1'b0, unlock_run};
  end

  always_ff @(posedge clk) begin
    if (rst || !link_up) begin
      st_q     <= ST_SEED;
      seed_cnt <= '0;
      good_cnt <= '0;
      bad_cnt  <= '0;
    end else begin
      case (st_q)
        ST_SEED: begin
          if (acc) begin
            if (seed_cnt == SEED_LAST) begin
              st_q     <= ST_HUNT;
              seed_cnt <= '0;
              good_cnt <= '0;
            end else begin
              seed_cnt <= seed_cnt + SEED_ONE;
            end
          end
        end
        ST_HUNT: begin
          if (lfsr_zero) begin
            st_q     <= ST_SEED;
            good_cnt <= '0;
          end else if (acc) begin
            if (!match) begin
              good_cnt <= '0;
            end else if (good_done) begin
              st_q     <= ST_LOCK;
              good_cnt <= '0;
              bad_cnt  <= '0;
            end else begin
              good_cnt <= good_inc[CNT_W-1:0];
            end
          end
        end
        ST_LOCK: begin
          if (lfsr_zero) begin
            st_q    <= ST_SEED;
            bad_cnt <= '0;
          end else if (acc) begin
            if (match) begin
              bad_cnt <= '0;
            end else if (bad_done) begin
              st_q     <= ST_HUNT;
              good_cnt <= '0;
              bad_cnt  <= '0;
            end else begin
              bad_cnt <= bad_inc[CNT_W-1:0];
            end
          end
        end
        default: st_q <= ST_SEED;
      endcase
    end
  end

  assign st = st_q;
endmodule

// File: rtl/prbs_checker.sv
module prbs_checker
  import prbs_pkg::*;
#(
  parameter int LEN    = 17,
  parameter int TAP_HI = 16,
  parameter int TAP_LO = 13,
  parameter int CNT_W  = 8,
  parameter logic [LEN-1:0] SEED = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             link_up,
  input  logic             rx_valid,
  input  logic [LEN-1:0]   rx_data,
  input  logic [CNT_W-1:0] lock_run,
  input  logic [CNT_W-1:0] unlock_run,
  output logic             locked,
  output logic             err_pulse,
  output logic [LEN-1:0]   err_mask
);
  logic [LEN-1:0] lfsr_q;
  logic [LEN-1:0] pred;
  logic           acc;
  logic           match;
  logic           lfsr_zero;
  logic           err_take;
  chk_state_t     st;

  prbs_step #(.LEN(LEN), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_step (
    .cur (lfsr_q),
    .nxt (pred)
  );

  prbs_lock_fsm #(.SEED_LEN(LEN), .CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .link_up    (link_up),
    .acc        (acc),
    .match      (match),
    .lfsr_zero  (lfsr_zero),
    .lock_run   (lock_run),
    .unlock_run (unlock_run),
    .st         (st)
  );

  always_comb begin
    acc       = rx_valid && link_up;
    match     = (rx_data == pred);
    lfsr_zero = (lfsr_q == '0);
    err_take  = acc && (st == ST_LOCK) && !lfsr_zero && !match;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q <= SEED;
    end else if (acc) begin
      if (st == ST_SEED)  lfsr_q <= {lfsr_q[LEN-2:0], rx_data[0]};
      else if (!lfsr_zero) lfsr_q <= pred;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_pulse <= 1'b0;
      err_mask  <= '0;
    end else begin
      err_pulse <= err_take;
      err_mask  <= err_take ? (rx_data ^ pred) : '0;
    end
  end

  assign locked = (st == ST_LOCK);
endmodule

// File: rtl/prbs_lock_pair.sv
module prbs_lock_pair #(
  parameter int LFSR_LEN = 17,
  parameter int TAP_HI   = 16,
  parameter int TAP_LO   = 13,
  parameter int CNT_W    = 8,
  parameter logic [LFSR_LEN-1:0] GEN_SEED = 1,
  parameter logic [LFSR_LEN-1:0] CHK_SEED = 1
) (
  input  logic                clk,
  input  logic                rst,
  output logic                gen_valid,
  input  logic                gen_ready,
  output logic [LFSR_LEN-1:0] gen_data,
  input  logic                rx_valid,
  output logic                rx_ready,
  input  logic [LFSR_LEN-1:0] rx_data,
  input  logic                link_up,
  input  logic [CNT_W-1:0]    lock_run,
  input  logic [CNT_W-1:0]    unlock_run,
  output logic                locked,
  output logic                err_pulse,
  output logic [LFSR_LEN-1:0] err_mask
);
  prbs_gen #(
    .LEN(LFSR_LEN), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .SEED(GEN_SEED)
  ) u_gen (
    .clk   (clk),
    .rst   (rst),
    .ready (gen_ready),
    .valid (gen_valid),
    .data  (gen_data)
  );

  prbs_checker #(
    .LEN(LFSR_LEN), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .CNT_W(CNT_W), .SEED(CHK_SEED)
  ) u_chk (
    .clk        (clk),
    .rst        (rst),
    .link_up    (link_up),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .lock_run   (lock_run),
    .unlock_run (unlock_run),
    .locked     (locked),
    .err_pulse  (err_pulse),
    .err_mask   (err_mask)
  );

  assign rx_ready = link_up;
endmodule

// File: rtl/prbs_lock_pair_chk.sv
module prbs_lock_pair_chk #(
  parameter int LFSR_LEN = 17
) (
  input logic                clk,
  input logic                rst,
  input logic                gen_valid,
  input logic                gen_ready,
  input logic [LFSR_LEN-1:0] gen_data,
  input logic                rx_valid,
  input logic                rx_ready,
  input logic                link_up,
  input logic                locked,
  input logic                err_pulse,
  input logic [LFSR_LEN-1:0] err_mask
);
  // R3
  gen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (gen_valid && !gen_ready) |=> $stable(gen_data));

  // R1
  gen_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    gen_valid |-> (gen_data != '0));

  // R7
  err_has_mask_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (err_mask != '0));

  // R7
  mask_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !err_pulse |-> (err_mask == '0));

  // R8
  err_when_locked_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> $past(locked));

  // R13
  err_needs_word_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> $past(rx_valid && rx_ready));

  // R5
  lock_needs_word_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(rx_valid && rx_ready));

  // R11
  link_down_chk: assert property (@(posedge clk) disable iff (rst)
    !link_up |=> (!locked && !err_pulse));
endmodule

bind prbs_lock_pair prbs_lock_pair_chk #(.LFSR_LEN(LFSR_LEN)) u_prbs_chk (
  .clk       (clk),
  .rst       (rst),
  .gen_valid (gen_valid),
  .gen_ready (gen_ready),
  .gen_data  (gen_data),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .link_up   (link_up),
  .locked    (locked),
  .err_pulse (err_pulse),
  .err_mask  (err_mask)
);

// File: tb/sim_prbs_lock_pair.sv
`timescale 1ns/1ps
module sim_prbs_lock_pair;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gen_ready = 1'b0;
  logic        gen_valid;
  logic [16:0] gen_data;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [16:0] rx_data = '0;
  logic        link_up = 1'b0;
  logic [7:0]  lock_run = 8'd8;
  logic [7:0]  unlock_run = 8'd8;
  logic        locked;
  logic        err_pulse;
  logic [16:0] err_mask;

  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  logic [16:0] tx = 17'h1ACE5;

  always #2 clk = ~clk;

  prbs_lock_pair u0 (
    .clk(clk), .rst(rst),
    .gen_valid(gen_valid), .gen_ready(gen_ready), .gen_data(gen_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .link_up(link_up), .lock_run(lock_run), .unlock_run(unlock_run),
    .locked(locked), .err_pulse(err_pulse), .err_mask(err_mask)
  );

  function automatic logic [16:0] step17(input logic [16:0] s);
    return {s[15:0], s[16] ^ s[13]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [16:0] flip);
    tx = step17(tx);
    rx_data = tx ^ flip;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_data = 17'h0AAAA;
  endtask

  task automatic push_raw(input logic [16:0] w);
    rx_data = w;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic seed_all(input logic [16:0] junk);
    for (int i = 0; i < 17; i++) push((i % 2 == 1) ? junk : 17'h0);
  endtask

  task automatic relink();
    link_up = 1'b0;
    @(negedge clk);
    link_up = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [16:0] gm;
    logic [16:0] hold;
    logic [16:0] f;
    int bad;
    int early;
    bit stayed;

    repeat (3) @(negedge clk);
    chk(gen_data == 17'h00001, "R1 reset seed", 32'(gen_data), 32'h1);
    chk(!gen_valid && !locked && !err_pulse && err_mask == '0, "R1 reset outputs",
        {gen_valid, locked, err_pulse, 12'h0, err_mask}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(gen_valid == 1'b1, "R3 valid after reset", 32'(gen_valid), 32'h1);
    chk(gen_data == 17'h00001, "R3 no step without ready", 32'(gen_data), 32'h1);

    gen_ready = 1'b1;
    gm = 17'h00001; bad = 0; early = 0;
    for (int i = 0; i < 131071; i++) begin
      if (gen_data !== gm) bad++;
      if (i > 0 && gen_data == 17'h00001) early++;
      gm = step17(gm);
      @(negedge clk);
    end
    chk(bad == 0, "R1 sequence mismatches", 32'(bad), 32'h0);
    chk(early == 0, "R2 early repeat", 32'(early), 32'h0);
    chk(gen_data == 17'h00001, "R2 period wrap", 32'(gen_data), 32'h1);

    gen_ready = 1'b0;
    hold = gen_data;
    repeat (3) @(negedge clk);
    chk(gen_data == hold, "R3 hold", 32'(gen_data), 32'(hold));
    gen_ready = 1'b1;
    @(negedge clk);
    chk(gen_data == step17(hold), "R3 resume", 32'(gen_data), 32'(step17(hold)));

    for (int k = 1; k <= 8; k++) begin
      lock_run = 8'(k);
      unlock_run = 8'(9 - k);
      link_up = 1'b0;
      @(negedge clk);
      chk(!locked && !rx_ready, "R11 link down", {locked, rx_ready}, 32'h0);
      link_up = 1'b1;
      seed_all(17'h1FFFE);
      chk(!locked, "R4 seeded not locked", 32'(locked), 32'h0);
      for (int j = 0; j < k - 1; j++) begin
        push(17'h0);
        rx_data = 17'h15555;
        @(negedge clk);
      end
      chk(!locked, "R5 R13 before run end", 32'(locked), 32'h0);
      push(17'h0);
      chk(locked, "R5 lock at run end", 32'(locked), 32'h1);
      for (int j = 0; j < 8 - k; j++) begin
        f = 17'(1) << (j % 17);
        push(f);
        chk(err_pulse && err_mask == f, "R7 mask", 32'(err_mask), 32'(f));
        chk(locked, "R9 still locked", 32'(locked), 32'h1);
      end
      push(17'h10000);
      chk(err_pulse && err_mask == 17'h10000, "R7 mask last", 32'(err_mask), 32'h10000);
      chk(!locked, "R9 unlock at run end", 32'(locked), 32'h0);
    end

    lock_run = 8'd4;
    unlock_run = 8'd3;
    relink();
    seed_all(17'h0);
    for (int j = 0; j < 3; j++) push(17'h0);
    push(17'h00100);
    chk(!err_pulse && err_mask == '0, "R8 no strobe in acquisition", 32'(err_mask), 32'h0);
    for (int j = 0; j < 3; j++) push(17'h0);
    chk(!locked, "R6 count restarted", 32'(locked), 32'h0);
    push(17'h0);
    chk(locked, "R6 lock after fresh run", 32'(locked), 32'h1);

    push(17'h00003);
    chk(err_pulse && err_mask == 17'h00003, "R7 strobe", 32'(err_mask), 32'h3);
    @(negedge clk);
    chk(!err_pulse && err_mask == '0, "R7 one cycle only", {err_pulse, 14'h0, err_mask}, 32'h0);
    push(17'h0);
    push(17'h00040);
    push(17'h00040);
    chk(locked, "R9 good restarts bad count", 32'(locked), 32'h1);
    push(17'h00040);
    chk(!locked, "R9 unlock", 32'(locked), 32'h0);

    for (int j = 0; j < 3; j++) push(17'h0);
    chk(!locked, "R10 before relock", 32'(locked), 32'h0);
    push(17'h0);
    chk(locked, "R10 relock without reseed", 32'(locked), 32'h1);

    link_up = 1'b0;
    @(negedge clk);
    chk(!locked && !rx_ready && !err_pulse, "R11 drop", {locked, rx_ready, err_pulse}, 32'h0);
    for (int j = 0; j < 20; j++) push(17'h0);
    link_up = 1'b1;
    for (int j = 0; j < 20; j++) push(17'h0);
    chk(!locked, "R11 words ignored while down", 32'(locked), 32'h0);
    push(17'h0);
    chk(locked, "R11 reseed then lock", 32'(locked), 32'h1);

    lock_run = 8'd1;
    relink();
    stayed = 1'b1;
    for (int j = 0; j < 40; j++) begin
      push_raw(17'h0);
      if (locked) stayed = 1'b0;
    end
    chk(stayed, "R12 zero stream never locks", 32'(stayed), 32'h1);
    relink();
    seed_all(17'h0);
    push(17'h0);
    chk(locked, "R12 recovery", 32'(locked), 32'h1);

    lock_run = 8'd0;
    relink();
    seed_all(17'h0);
    push(17'h0);
    chk(locked, "R5 zero run acts as one", 32'(locked), 32'h1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule